// File: doc/BRIEF.md
# Multi-Lane Received Traffic Checker

This block watches the sample words delivered, one per lane and beat, on the receive side of a multi-lane streaming link. Each 64-bit word carries three counters: an identifier for the lane it belongs to, a running burst number, and a running word number. The block uses these embedded values to confirm that each lane delivered the right stream, in order, with burst boundaries where the start-of-burst marker says they are. It also confirms that the lanes were aligned to each other, which is the case only when neighbouring lanes carry identical counters in the same beat.

Every lane has four checks: identifier, word order, burst rule and alignment. Each check has a sticky flag and a saturating error counter. Control logic reads these directly and wipes them with a single clear input. The clear input also forgets the per-lane reference values, so the next word after a clear starts a fresh sequence.

Top module: `tc_traffic_checker`

## Requirements
- R1: Bits [63:59] of each accepted word must equal ID_BASE plus the lane index. A mismatch is an identifier error, check index 0.
- R2: Bits [31:0], the word number, must be strictly greater than the word number held as that lane's reference. Otherwise it is an order error, check index 1.
- R3: When in_sob is high, bits [58:32], the burst number, must be strictly greater than the lane's reference burst number. Otherwise it is a burst error, check index 2.
- R4: When in_sob is low, the burst number must equal the lane's reference burst number. Otherwise it is a burst error, check index 2.
- R5: Lane i compares its word number and burst number with lane i+1. The last lane compares with the lane before it. Any difference is an alignment error, check index 3.
- R6: The first accepted word after reset or clear only loads the references. R2 to R4 are not applied to it. R1 and R5 still are.
- R7: A lane's references are loaded only from a word that had none of the four errors on that lane.
- R8: A word is accepted only on a cycle where in_valid is high and clr is low. On any other cycle, flags and counters keep their values.
- R9: The error flag for lane l and check c is err_flag[l*4+c]. It rises at the clock edge that accepts the failing word and stays high until clr.
- R10: The counter for lane l and check c is err_cnt[(l*4+c)*16 +: 16]. It adds one for each failing word and holds at 65535.
- R11: While clr is high, all flags, counters and references go to zero at the next edge. A word presented in that same cycle is ignored.
- R12: After reset, all flags and counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr | input | 1 | Clears flags, counters and references |
| in_valid | input | 1 | A word is present on every lane this cycle |
| in_sob | input | 1 | This beat opens a new burst |
| in_data | input | NUM_LANES*64 | Lane words, lane 0 in the lowest bits |
| err_flag | output | NUM_LANES*4 | Sticky error flags, one per lane and check |
| err_cnt | output | NUM_LANES*4*CNT_W | Saturating error counters, one per lane and check |

## Verification
The bench targets the following corner cases, and what a faulty design would do in each:

- **Word following a failed word.** The bench sends a jump in word number on a word that fails its identifier. A design that loads its references from failed words then flags an order error on the next, smaller number on that lane; a correct design does not. On the other lane the same jump passes, so the smaller number that follows must be flagged there.
- **Burst rule in both directions.** The bench applies a start-of-burst with an unchanged burst number, then a burst number change without the marker. A design that tests only one direction leaves one of these uncounted.
- **Lane skew.** The bench puts a one-word skew between the lanes. Each lane must raise its own alignment flag.
- **Clear with a word in the same cycle.** A word presented alongside clr must leave nothing behind. The first word after the clear carries a lower word number and must not raise an order error.
- **Counter saturation.** A long run of failing words must stop the counter at its maximum rather than wrap it back to zero.

// File: rtl/tc_pkg.sv
package tc_pkg;
  // Sample word layout (fixed by the sender's pattern format)
  localparam int WORD_W  = 64;
  localparam int WC_W    = 32;           // word number,  bits [31:0]
  localparam int BC_W    = 27;           // burst number, bits [58:32]
  localparam int ID_W    = WORD_W - BC_W - WC_W;  // lane identifier, bits [63:59]

  // Check indices within a lane's flag/counter group
  localparam int NUM_CHK   = 4;
  localparam int CHK_ID    = 0;
  localparam int CHK_ORDER = 1;
  localparam int CHK_BURST = 2;
  localparam int CHK_SKEW  = 3;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [BC_W-1:0] bc;
    logic [WC_W-1:0] wc;
  } sample_t;
endpackage

// File: rtl/tc_err_track.sv
// One sticky flag plus one saturating counter for a single lane/check pair.
module tc_err_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             hit,
  output logic             flag,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             flag_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    flag_d = flag;
    cnt_d  = cnt;
    cnt_en = 1'b0;
    if (clr) begin
      flag_d = 1'b0;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (hit) begin
      flag_d = 1'b1;
      if (cnt != CNT_MAX) begin
        cnt_d  = cnt + 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else begin
      flag <= flag_d;
      if (cnt_en) cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/tc_lane_check.sv
// Per-lane checks against the lane's own last good word and its neighbour.
module tc_lane_check
  import tc_pkg::*;
#(
  parameter logic [ID_W-1:0] EXP_ID  = '0,
  parameter bit              HAS_NBR = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                take,      // accepted beat (valid and not clear)
  input  logic                sob,
  input  sample_t             word,
  input  logic [BC_W-1:0]     nbr_bc,
  input  logic [WC_W-1:0]     nbr_wc,
  output logic [NUM_CHK-1:0]  err_hit
);
  logic            has_ref_q, has_ref_d;
  logic [WC_W-1:0] ref_wc_q,  ref_wc_d;
  logic [BC_W-1:0] ref_bc_q,  ref_bc_d;
  logic            ref_en;

  logic id_bad, ord_bad, bst_bad, skew_bad, any_bad;

  // Check evaluation
  always_comb begin
    id_bad  = (word.id != EXP_ID);
    ord_bad = has_ref_q && !(word.wc > ref_wc_q);
    if (sob) bst_bad = has_ref_q && !(word.bc > ref_bc_q);
    else     bst_bad = has_ref_q && (word.bc != ref_bc_q);
  end

  generate
    if (HAS_NBR) begin : g_nbr
      assign skew_bad = (word.wc != nbr_wc) || (word.bc != nbr_bc);
    end else begin : g_solo
      assign skew_bad = 1'b0;
    end
  endgenerate

  assign any_bad = id_bad | ord_bad | bst_bad | skew_bad;

  always_comb begin
    err_hit            = '0;
    err_hit[CHK_ID]    = take & id_bad;
    err_hit[CHK_ORDER] = take & ord_bad;
    err_hit[CHK_BURST] = take & bst_bad;
    err_hit[CHK_SKEW]  = take & skew_bad;
  end

  // Reference next state
  always_comb begin
    has_ref_d = has_ref_q;
    ref_wc_d  = ref_wc_q;
    ref_bc_d  = ref_bc_q;
    ref_en    = 1'b0;
    if (clr) begin
      has_ref_d = 1'b0;
      ref_wc_d  = '0;
      ref_bc_d  = '0;
      ref_en    = 1'b1;
    end else if (take && !any_bad) begin
      has_ref_d = 1'b1;
      ref_wc_d  = word.wc;
      ref_bc_d  = word.bc;
      ref_en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      has_ref_q <= 1'b0;
      ref_wc_q  <= '0;
      ref_bc_q  <= '0;
    end else if (ref_en) begin
      has_ref_q <= has_ref_d;
      ref_wc_q  <= ref_wc_d;
      ref_bc_q  <= ref_bc_d;
    end
  end
endmodule

// File: rtl/tc_traffic_checker.sv
// Multi-lane received traffic checker: top level.
module tc_traffic_checker
  import tc_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int CNT_W     = 16,
  parameter int ID_BASE   = 5
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clr,
  input  logic                                in_valid,
  input  logic                                in_sob,
  input  logic [NUM_LANES*WORD_W-1:0]         in_data,
  output logic [NUM_LANES*NUM_CHK-1:0]        err_flag,
  output logic [NUM_LANES*NUM_CHK*CNT_W-1:0]  err_cnt
);
  localparam int NUM_TRK = NUM_LANES * NUM_CHK;

  logic                 take;
  sample_t              lane_word [NUM_LANES];
  logic [NUM_TRK-1:0]   hit_vec;

  assign take = in_valid & ~clr;

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam int NBR = (NUM_LANES == 1) ? 0 :
                           ((i < NUM_LANES - 1) ? i + 1 : i - 1);
      localparam logic [ID_W-1:0] EXP = ID_W'(ID_BASE + i);

      assign lane_word[i] = sample_t'(in_data[i*WORD_W +: WORD_W]);

      tc_lane_check #(
        .EXP_ID  (EXP),
        .HAS_NBR (NUM_LANES > 1)
      ) u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .take    (take),
        .sob     (in_sob),
        .word    (lane_word[i]),
        .nbr_bc  (lane_word[NBR].bc),
        .nbr_wc  (lane_word[NBR].wc),
        .err_hit (hit_vec[i*NUM_CHK +: NUM_CHK])
      );
    end

    for (genvar k = 0; k < NUM_TRK; k++) begin : g_trk
      tc_err_track #(.CNT_W(CNT_W)) u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .hit   (hit_vec[k]),
        .flag  (err_flag[k]),
        .cnt   (err_cnt[k*CNT_W +: CNT_W])
      );
    end
  endgenerate
endmodule

// File: rtl/tc_traffic_checker_sva.sv
module tc_traffic_checker_sva
  import tc_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int CNT_W     = 16,
  parameter int ID_BASE   = 5
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                clr,
  input logic                                in_valid,
  input logic                                in_sob,
  input logic [NUM_LANES*WORD_W-1:0]         in_data,
  input logic [NUM_LANES*NUM_CHK-1:0]        err_flag,
  input logic [NUM_LANES*NUM_CHK*CNT_W-1:0]  err_cnt
);
  localparam int NUM_TRK = NUM_LANES * NUM_CHK;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R11
  clr_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (err_flag == '0) && (err_cnt == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> ($stable(err_flag) && $stable(err_cnt)));

  generate
    for (genvar k = 0; k < NUM_TRK; k++) begin : g_k
      // R9
      sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag[k] && !clr) |=> err_flag[k]);

      // R10
      sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt[k*CNT_W +: CNT_W] == CNT_MAX && !clr)
          |=> (err_cnt[k*CNT_W +: CNT_W] == CNT_MAX));
    end

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_l
      localparam logic [ID_W-1:0] EXP = ID_W'(ID_BASE + i);
      // R1
      id_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr && in_data[i*WORD_W + WORD_W - ID_W +: ID_W] != EXP)
          |=> err_flag[i*NUM_CHK + CHK_ID]);
    end
  endgenerate
endmodule

bind tc_traffic_checker tc_traffic_checker_sva #(
  .NUM_LANES (NUM_LANES),
  .CNT_W     (CNT_W),
  .ID_BASE   (ID_BASE)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .in_valid (in_valid),
  .in_sob   (in_sob),
  .in_data  (in_data),
  .err_flag (err_flag),
  .err_cnt  (err_cnt)
);

// File: tb/sim_tc_traffic_checker.sv
module sim_tc_traffic_checker;
  import tc_pkg::*;

  localparam int CLK_P = 10;
  localparam int LANES = 2;
  localparam int CW    = 16;
  localparam int IDB   = 5;
  localparam int CMAX  = 65535;

  logic clk = 1'b0;
  logic rst_n, clr, in_valid, in_sob;
  logic [LANES*WORD_W-1:0]     in_data;
  logic [LANES*NUM_CHK-1:0]    err_flag;
  logic [LANES*NUM_CHK*CW-1:0] err_cnt;

  int n_chk = 0;
  int n_err = 0;
  int exp_cnt [LANES][NUM_CHK];
  logic [31:0] wc;
  logic [26:0] bc;

  always #(CLK_P/2) clk = ~clk;

  tc_traffic_checker #(.NUM_LANES(LANES), .CNT_W(CW), .ID_BASE(IDB)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_sob(in_sob),
    .in_data(in_data), .err_flag(err_flag), .err_cnt(err_cnt)
  );

  function automatic logic [63:0] mkw(logic [4:0] id, logic [26:0] b, logic [31:0] w);
    return {id, b, w};
  endfunction

  task automatic beat(logic v, logic s, logic c, logic [63:0] w0, logic [63:0] w1);
    in_valid = v; in_sob = s; clr = c; in_data = {w1, w0};
    @(negedge clk);
    in_valid = 1'b0; in_sob = 1'b0; clr = 1'b0;
  endtask

  task automatic good(logic s);
    wc = wc + 1;
    if (s) bc = bc + 1;
    beat(1'b1, s, 1'b0, mkw(5'd5, bc, wc), mkw(5'd6, bc, wc));
  endtask

  task automatic hit(int l, int c);
    if (exp_cnt[l][c] < CMAX) exp_cnt[l][c]++;
  endtask

  task automatic zero_model();
    foreach (exp_cnt[l, c]) exp_cnt[l][c] = 0;
  endtask

  task automatic check_all(string tag);
    for (int l = 0; l < LANES; l++) begin
      for (int c = 0; c < NUM_CHK; c++) begin
        int k = l*NUM_CHK + c;
        int ac = int'(err_cnt[k*CW +: CW]);
        logic ef = (exp_cnt[l][c] != 0);
        n_chk++;
        if (err_flag[k] !== ef) begin
          n_err++;
          $display("FAIL %s lane%0d chk%0d flag actual=%0b expected=%0b", tag, l, c, err_flag[k], ef);
        end
        n_chk++;
        if (ac != exp_cnt[l][c]) begin
          n_err++;
          $display("FAIL %s lane%0d chk%0d count actual=%0d expected=%0d", tag, l, c, ac, exp_cnt[l][c]);
        end
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; in_sob = 1'b0; in_data = '0;
    wc = '0; bc = '0; zero_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R12 reset state");
  endtask

  task automatic t_clean();
    good(1'b1); good(1'b0); good(1'b0); good(1'b0); good(1'b1); good(1'b0);
    check_all("R2 R3 R4 R5 R6 clean stream");
  endtask

  task automatic t_id();
    wc = wc + 1;
    beat(1'b1, 1'b0, 1'b0, mkw(5'd5, bc, wc), mkw(5'd7, bc, wc));
    hit(1, CHK_ID);
    good(1'b0); good(1'b0);
    check_all("R1 identifier");
  endtask

  task automatic t_order();
    beat(1'b1, 1'b0, 1'b0, mkw(5'd5, bc, wc), mkw(5'd6, bc, wc));
    hit(0, CHK_ORDER); hit(1, CHK_ORDER);
    good(1'b0);
    check_all("R2 order");
  endtask

  task automatic t_burst();
    wc = wc + 1;
    beat(1'b1, 1'b1, 1'b0, mkw(5'd5, bc, wc), mkw(5'd6, bc, wc));
    hit(0, CHK_BURST); hit(1, CHK_BURST);
    check_all("R3 burst at start");
    wc = wc + 1;
    beat(1'b1, 1'b0, 1'b0, mkw(5'd5, bc + 1, wc), mkw(5'd6, bc + 1, wc));
    hit(0, CHK_BURST); hit(1, CHK_BURST);
    good(1'b0);
    check_all("R4 burst inside");
  endtask

  task automatic t_skew();
    wc = wc + 1;
    beat(1'b1, 1'b0, 1'b0, mkw(5'd5, bc, wc), mkw(5'd6, bc, wc + 1));
    hit(0, CHK_SKEW); hit(1, CHK_SKEW);
    wc = wc + 1;
    good(1'b0);
    check_all("R5 alignment");
  endtask

  task automatic t_ref_hold();
    logic [31:0] w0 = wc;
    beat(1'b1, 1'b0, 1'b0, mkw(5'd0, bc, w0 + 100), mkw(5'd6, bc, w0 + 100));
    hit(0, CHK_ID);
    beat(1'b1, 1'b0, 1'b0, mkw(5'd5, bc, w0 + 50), mkw(5'd6, bc, w0 + 50));
    hit(1, CHK_ORDER);
    wc = w0 + 200;
    good(1'b0);
    check_all("R7 reference only from good word");
  endtask

  task automatic t_idle();
    for (int n = 0; n < 3; n++)
      beat(1'b0, 1'b1, 1'b0, mkw(5'd0, 27'd0, 32'd0), mkw(5'd31, 27'd9, 32'd0));
    check_all("R8 invalid cycles ignored");
    good(1'b0);
    check_all("R9 flags stay set");
  endtask

  task automatic t_clear();
    beat(1'b1, 1'b1, 1'b1, mkw(5'd0, 27'd0, 32'd0), mkw(5'd0, 27'd3, 32'd0));
    zero_model();
    check_all("R11 clear with word same cycle");
    wc = 32'd3; bc = 27'd1;
    beat(1'b1, 1'b0, 1'b0, mkw(5'd5, bc, wc), mkw(5'd6, bc, wc));
    good(1'b0);
    check_all("R6 first word after clear");
  endtask

  task automatic t_sat();
    for (int n = 0; n < CMAX + 5; n++) begin
      wc = wc + 1;
      beat(1'b1, 1'b0, 1'b0, mkw(5'd0, bc, wc), mkw(5'd6, bc, wc));
      hit(0, CHK_ID);
    end
    check_all("R10 saturation");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired after %0d checks", n_chk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_clean();
    t_id();
    t_order();
    t_burst();
    t_skew();
    t_ref_hold();
    t_idle();
    t_clear();
    t_sat();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule